// File: doc/BRIEF.md
# Address Acknowledge Timing Controller

This controller sits on the slave side of a pipelined, split-transaction system bus. It decides the cycle in which the address acknowledge pulse for each address tenure goes out. Two conditions hold the acknowledge back. The first is a programmable snoop window: a minimum count of address wait states, applied only to global (snoopable) accesses that hit a memory bank owned by this bus. The second is a pipeline limit: the bus may be at most one level deep, so a new tenure is not acknowledged while the data tenure opened by the previous acknowledge is still running.

An address retry seen while a tenure waits for its acknowledge aborts that tenure without an acknowledge. Data beats can be acknowledged early, before the address acknowledge. If such a beat belongs to the aborted tenure, a cancel pulse goes out in the abort cycle, so that the beat is discarded before it is stored.

Top module: `addr_ack_ctrl`

## Requirements
- R1: While rst_ni is low, aack_o and cancel_o are 0 and no tenure is pending.
- R2: A tenure starts in a cycle with ts_i high when none is pending. A ts_i while one is pending is ignored and produces no acknowledge of its own.
- R3: A tenure sampled with bank_hit_i=1 and gbl_i=1 (snoop tenure) starting in cycle t gets aack_o no earlier than cycle t+1+W, where W is wait_cfg_i sampled in cycle t.
- R4: A tenure with bank_hit_i=0 or gbl_i=0 ignores wait_cfg_i and is eligible from cycle t+1.
- R5: A snoop tenure with W=0 is eligible from cycle t+1.
- R6: aack_o is a one-cycle pulse that closes its tenure; each tenure gets at most one.
- R7: aack_o opens a data tenure. While a data tenure is open, aack_o stays low. data_done_i while a data tenure is open closes it at the next edge, and a waiting eligible tenure is then acknowledged in that next cycle.
- R8: artry_i in a cycle with a pending tenure forces aack_o low in that cycle and aborts the tenure, so it is never acknowledged. artry_i with nothing pending has no effect.
- R9: cancel_o is high exactly in an abort cycle in which an early beat of the pending tenure was seen. An early beat is a ta_i while the tenure is pending and no data tenure is open, seen in the abort cycle or in any earlier cycle of the same tenure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ts_i | input | 1 | Address tenure start |
| bank_hit_i | input | 1 | Address hits a bank owned by this bus (sampled with ts_i) |
| gbl_i | input | 1 | Access is global/snoopable (sampled with ts_i) |
| wait_cfg_i | input | WAIT_W | Minimum address wait states for snoop tenures |
| ta_i | input | 1 | Data beat acknowledge |
| data_done_i | input | 1 | Current data tenure ends |
| artry_i | input | 1 | Address retry |
| aack_o | output | 1 | Address acknowledge pulse |
| cancel_o | output | 1 | Cancel for an early data beat of a retried tenure |

## Verification
Two events can land in the same cycle. The snoop wait count can expire in the very cycle that data_done_i ends the open data tenure, and a retry can arrive together with the first early data beat. The bench drives both on purpose: a snoop tenure whose count runs out while data_done_i is high, and artry_i together with ta_i when no beat came earlier. A behavioural model decides aack_o and cancel_o for every cycle, and the bench compares them: the acknowledge must follow one cycle after the data tenure closes, and the cancel must fire in the retry cycle itself.

// File: rtl/aack_pkg.sv
package aack_pkg;
  typedef enum logic {
    TEN_PLAIN = 1'b0,
    TEN_SNOOP = 1'b1
  } tenure_kind_e;

  function automatic tenure_kind_e classify(input logic hit, input logic glob);
    return (hit && glob) ? TEN_SNOOP : TEN_PLAIN;
  endfunction
endpackage

// File: rtl/aack_wait_cnt.sv
module aack_wait_cnt #(
  parameter int WAIT_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [WAIT_W-1:0] load_val_i,
  input  logic              run_i,
  output logic              expired_o
);
  logic [WAIT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        cnt_q <= '0;
    else if (load_i)                    cnt_q <= load_val_i;
    else if (run_i && cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/aack_pipe_trk.sv
module aack_pipe_trk (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic open_i,
  input  logic done_i,
  output logic data_open_o
);
  logic open_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      open_q <= 1'b0;
    else if (open_i)  open_q <= 1'b1;
    else if (done_i)  open_q <= 1'b0;
  end

  assign data_open_o = open_q;
endmodule

// File: rtl/aack_retry_unit.sv
module aack_retry_unit (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic pend_i,
  input  logic ack_i,
  input  logic data_open_i,
  input  logic ta_i,
  input  logic artry_i,
  output logic abort_o,
  output logic cancel_o
);
  logic early_q;
  logic early_now;

  // beat belongs to the pending tenure only while no data tenure is open
  assign early_now = pend_i & ta_i & ~data_open_i;
  assign abort_o   = pend_i & artry_i;
  assign cancel_o  = abort_o & (early_now | early_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             early_q <= 1'b0;
    else if (start_i || ack_i || abort_o)    early_q <= 1'b0;
    else if (early_now)                      early_q <= 1'b1;
  end
endmodule

// File: rtl/addr_ack_ctrl.sv
module addr_ack_ctrl
  import aack_pkg::*;
#(
  parameter int WAIT_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ts_i,
  input  logic              bank_hit_i,
  input  logic              gbl_i,
  input  logic [WAIT_W-1:0] wait_cfg_i,
  input  logic              ta_i,
  input  logic              data_done_i,
  input  logic              artry_i,
  output logic              aack_o,
  output logic              cancel_o
);
  logic              pend_q;
  logic              accept;
  logic              expired;
  logic              data_open;
  logic              abort;
  logic              ack;
  tenure_kind_e      kind;
  logic [WAIT_W-1:0] load_val;

  assign accept   = ts_i & ~pend_q;
  assign kind     = classify(bank_hit_i, gbl_i);
  assign load_val = (kind == TEN_SNOOP) ? wait_cfg_i : '0;

  aack_wait_cnt #(.WAIT_W(WAIT_W)) u_wait (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (accept),
    .load_val_i (load_val),
    .run_i      (pend_q),
    .expired_o  (expired)
  );

  aack_pipe_trk u_pipe (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .open_i      (ack),
    .done_i      (data_done_i),
    .data_open_o (data_open)
  );

  aack_retry_unit u_retry (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (accept),
    .pend_i      (pend_q),
    .ack_i       (ack),
    .data_open_i (data_open),
    .ta_i        (ta_i),
    .artry_i     (artry_i),
    .abort_o     (abort),
    .cancel_o    (cancel_o)
  );

  // retry in the same cycle wins over the acknowledge
  assign ack    = pend_q & expired & ~data_open & ~artry_i;
  assign aack_o = ack;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            pend_q <= 1'b0;
    else if (accept)        pend_q <= 1'b1;
    else if (ack || abort)  pend_q <= 1'b0;
  end
endmodule

// File: rtl/addr_ack_ctrl_chk.sv
module addr_ack_ctrl_chk #(
  parameter int WAIT_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ts_i,
  input logic              bank_hit_i,
  input logic              gbl_i,
  input logic [WAIT_W-1:0] wait_cfg_i,
  input logic              data_done_i,
  input logic              artry_i,
  input logic              aack_o,
  input logic              cancel_o
);
  logic              c_pend;
  logic              c_open;
  logic [WAIT_W-1:0] c_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      c_pend <= 1'b0;
      c_cnt  <= '0;
    end else if (ts_i && !c_pend) begin
      c_pend <= 1'b1;
      c_cnt  <= (bank_hit_i && gbl_i) ? wait_cfg_i : '0;
    end else begin
      if (aack_o || artry_i)        c_pend <= 1'b0;
      if (c_pend && c_cnt != '0)    c_cnt  <= c_cnt - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          c_open <= 1'b0;
    else if (aack_o)      c_open <= 1'b1;
    else if (data_done_i) c_open <= 1'b0;
  end

  p_min_wait_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    aack_o |-> (c_pend && c_cnt == '0));
  p_single_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    aack_o |=> !aack_o);
  p_pipe_limit_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    aack_o |-> !c_open);
  p_retry_blocks_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    artry_i |-> !aack_o);
  p_cancel_on_abort_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cancel_o |-> (artry_i && c_pend));
endmodule

bind addr_ack_ctrl addr_ack_ctrl_chk #(.WAIT_W(WAIT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ts_i        (ts_i),
  .bank_hit_i  (bank_hit_i),
  .gbl_i       (gbl_i),
  .wait_cfg_i  (wait_cfg_i),
  .data_done_i (data_done_i),
  .artry_i     (artry_i),
  .aack_o      (aack_o),
  .cancel_o    (cancel_o)
);

// File: tb/sim_addr_ack_ctrl.sv
`timescale 1ns/1ps
module sim_addr_ack_ctrl;
  localparam int WAIT_W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ts = 0, hit = 0, gbl = 0, ta = 0, done = 0, artry = 0;
  logic [WAIT_W-1:0] wcfg = '0;
  logic aack, cancel;

  int checks = 0;
  int fails = 0;
  bit finished = 0;
  string cur_req = "R1";

  // model state
  bit m_pend = 0, m_open = 0, m_early = 0;
  int m_cnt = 0;

  always #2 clk = ~clk;

  addr_ack_ctrl #(.WAIT_W(WAIT_W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .ts_i(ts), .bank_hit_i(hit), .gbl_i(gbl),
    .wait_cfg_i(wcfg), .ta_i(ta), .data_done_i(done), .artry_i(artry),
    .aack_o(aack), .cancel_o(cancel)
  );

  task automatic check(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0b expected=%0b t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic cyc(input logic t_s, input logic t_h, input logic t_g,
                     input logic t_ta, input logic t_d, input logic t_r);
    bit e_ack, e_can, abort, acc;
    @(negedge clk);
    ts = t_s; hit = t_h; gbl = t_g; ta = t_ta; done = t_d; artry = t_r;
    #1;
    acc   = t_s && !m_pend;
    e_ack = m_pend && m_cnt == 0 && !m_open && !t_r;
    abort = m_pend && t_r;
    e_can = abort && ((t_ta && !m_open) || m_early);
    check(cur_req, "aack_o", aack, e_ack);
    check(cur_req, "cancel_o", cancel, e_can);
    @(posedge clk);
    if (acc) begin
      m_pend = 1; m_early = 0;
      m_cnt = (t_h && t_g) ? int'(wcfg) : 0;
    end else if (e_ack || abort) begin
      m_pend = 0; m_early = 0;
    end else if (m_pend) begin
      if (m_cnt > 0) m_cnt--;
      if (t_ta && !m_open) m_early = 1;
    end
    if (e_ack) m_open = 1;
    else if (m_open && t_d) m_open = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0);
  endtask

  task automatic close_data();
    cyc(0, 0, 0, 0, 1, 0);
    idle(1);
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1: outputs low during reset, even with stimulus present
    repeat (2) @(negedge clk);
    ts = 1; hit = 1; gbl = 1; artry = 1; ta = 1;
    #1;
    check("R1", "aack_o in reset", aack, 1'b0);
    check("R1", "cancel_o in reset", cancel, 1'b0);
    @(negedge clk);
    ts = 0; hit = 0; gbl = 0; artry = 0; ta = 0;
    rst_n = 1;
    idle(2);

    // R4: plain (not global) access ignores a large wait count
    cur_req = "R4"; wcfg = 5;
    cyc(1, 1, 0, 0, 0, 0); idle(3); close_data();
    // R4: global but no bank hit also ignores it
    wcfg = 6;
    cyc(1, 0, 1, 0, 0, 0); idle(3); close_data();

    // R3: snoop tenure waits W cycles
    cur_req = "R3"; wcfg = 3;
    cyc(1, 1, 1, 0, 0, 0); idle(6); close_data();
    wcfg = 9;
    cyc(1, 1, 1, 0, 0, 0); idle(12); close_data();

    // R5: zero wait on a snoop tenure
    cur_req = "R5"; wcfg = 0;
    cyc(1, 1, 1, 0, 0, 0); idle(2); close_data();

    // R7: pipelined tenure held until data tenure ends
    cur_req = "R7"; wcfg = 0;
    cyc(1, 1, 1, 0, 0, 0); idle(1);
    cyc(1, 0, 0, 0, 0, 0); idle(4);
    cyc(0, 0, 0, 0, 1, 0); idle(2); close_data();
    // R7: wait expiry coincides with data_done_i
    wcfg = 0;
    cyc(1, 1, 1, 0, 0, 0); idle(1);
    wcfg = 2;
    cyc(1, 1, 1, 0, 0, 0); idle(1);
    cyc(0, 0, 0, 0, 1, 0); idle(3); close_data();

    // R2: second start while pending is ignored
    cur_req = "R2"; wcfg = 4;
    cyc(1, 1, 1, 0, 0, 0);
    cyc(1, 0, 0, 0, 0, 0);
    idle(6); close_data(); idle(3);

    // R9: early beat then retry -> cancel
    cur_req = "R9"; wcfg = 4;
    cyc(1, 1, 1, 0, 0, 0);
    cyc(0, 0, 0, 1, 0, 0); idle(1);
    cyc(0, 0, 0, 0, 0, 1); idle(6);
    // R9: retry and first beat in the same cycle
    wcfg = 5;
    cyc(1, 1, 1, 0, 0, 0); idle(1);
    cyc(0, 0, 0, 1, 0, 1); idle(7);

    // R8: retry with no beat -> abort, no cancel, no aack
    cur_req = "R8"; wcfg = 3;
    cyc(1, 1, 1, 0, 0, 0); idle(1);
    cyc(0, 0, 0, 0, 0, 1); idle(5);
    // R8: retry exactly in the eligible cycle
    wcfg = 1;
    cyc(1, 1, 1, 0, 0, 0); idle(1);
    cyc(0, 0, 0, 0, 0, 1); idle(4);
    // R8: retry with nothing pending has no effect; next tenure normal
    cyc(0, 0, 0, 1, 0, 1);
    wcfg = 2;
    cyc(1, 1, 1, 0, 0, 0); idle(4); close_data();

    // R6: back-to-back tenures, each pulse single
    cur_req = "R6"; wcfg = 0;
    for (int k = 0; k < 4; k++) begin
      cyc(1, 1, 1, 0, 0, 0); idle(1); close_data();
    end
    // R9: beat during an open data tenure is not early
    cur_req = "R9"; wcfg = 0;
    cyc(1, 1, 1, 0, 0, 0); idle(1);
    wcfg = 3;
    cyc(1, 1, 1, 1, 0, 0);
    cyc(0, 0, 0, 0, 0, 1); idle(2); close_data();

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule